// File: doc/BRIEF.md
# Collision-Vector Initiation Controller for a Shared-Stage Arithmetic Pipeline

This block decides, cycle by cycle, when a new add or a new multiply may enter an arithmetic pipeline whose eight stage resources are shared between the two kinds of operation. Each kind has a fixed reservation table. From the two tables the controller derives four collision vectors at elaboration time: add after add, add after multiply, multiply after add and multiply after multiply. It keeps one forbidden-latency shift register per kind. On every initiation, the vectors of the started kind are OR-ed into both registers, and both registers advance by one position each cycle.

A requester pulses a one-cycle strobe per wanted operation. The strobe is held inside the block as a pending request until it can start without a clash. A grant output marks the cycle in which the operation enters the pipeline. A registered stage-busy vector shows which stages are occupied in the current cycle. The arithmetic itself lives elsewhere. When both kinds are pending and both are allowed, the older request goes first. A younger request that is allowed may start ahead of an older one that is still blocked.

Top module: `ipc_initiation_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, both grant outputs are low and `stage_busy_o` is all zero.
- R2: A strobe sampled at a clock edge, with nothing in flight, produces its grant two edges later, in the cycle where stage U (bit 0) is busy. At most one grant is high in any cycle.
- R3: An add occupies U at offset 0, S (bit 1) at offsets 1 and 3, A (bit 2) at offsets 1 and 2, and R (bit 3) at offsets 2 and 3, counted in cycles from its grant.
- R4: A multiply occupies U at offset 0, E (bit 7) at 1, M (bit 4) at 1 to 4, N (bit 5) at 5 and 6, A at 6 and R at 7. Bit 6 (D) is never set.
- R5: Two adds start at least 3 cycles apart.
- R6: Two multiplies start at least 4 cycles apart.
- R7: An add may start 1, 2, 3 or 6 and more cycles after a multiply, but never 4 or 5 cycles after it.
- R8: A multiply may start any number of cycles (one or more) after an add.
- R9: A denied request stays pending and is granted in the first cycle its kind is allowed. A younger request of the other kind that is allowed earlier starts first.
- R10: When both kinds are strobed in the same cycle, the add is granted first and the multiply in the next allowed cycle.
- R11: When both kinds are pending and allowed in the same cycle, the one strobed earlier is granted.
- R12: A strobe of a kind that is already pending and not granted in that cycle is absorbed. It produces no further grant.
- R13: No stage is ever claimed by two operations in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| add_req_i | input | 1 | One-cycle strobe requesting an add initiation |
| mul_req_i | input | 1 | One-cycle strobe requesting a multiply initiation |
| add_grant_o | output | 1 | High in the cycle an add enters the pipeline |
| mul_grant_o | output | 1 | High in the cycle a multiply enters the pipeline |
| stage_busy_o | output | NUM_STAGES | Per-stage occupancy this cycle: U0 S1 A2 R3 M4 N5 D6 E7 |

## Verification
A corrupted forbidden-latency register does not stay hidden. The next request of the affected kind starts one or more cycles earlier or later than the reservation tables allow. A scoreboard keyed on the exact grant cycle catches this within a few cycles of the stimulus. A wrong occupancy window shows up directly on `stage_busy_o`, which is compared against the tables in every cycle of an operation's life, including the overlap where an add issued after a multiply finishes first. A wrong age or pending record appears as a grant order swapped, a missing grant or an extra grant once the requests drain.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

  localparam int NUM_STAGES = 8;
  localparam int WIN        = 8;
  localparam int NUM_OPS    = 2;

  // operation kinds
  localparam int OP_ADD = 0;
  localparam int OP_MUL = 1;

  // stage bit positions in the occupancy vector
  localparam int SG_U = 0;
  localparam int SG_S = 1;
  localparam int SG_A = 2;
  localparam int SG_R = 3;
  localparam int SG_M = 4;
  localparam int SG_N = 5;
  localparam int SG_E = 7;

  typedef logic [WIN-1:0] row_t;
  typedef row_t [NUM_STAGES-1:0] table_t;

  // Reservation table: bit k of row s set when the stage s is used k cycles
  // after the operation starts.
  function automatic table_t resv_table(input int op);
    table_t t;
    t = '0;
    if (op == OP_ADD) begin
      t[SG_U][0] = 1'b1;
      t[SG_S][1] = 1'b1;
      t[SG_S][3] = 1'b1;
      t[SG_A][1] = 1'b1;
      t[SG_A][2] = 1'b1;
      t[SG_R][2] = 1'b1;
      t[SG_R][3] = 1'b1;
    end else begin
      t[SG_U][0] = 1'b1;
      t[SG_E][1] = 1'b1;
      for (int k = 1; k <= 4; k++) t[SG_M][k] = 1'b1;
      t[SG_N][5] = 1'b1;
      t[SG_N][6] = 1'b1;
      t[SG_A][6] = 1'b1;
      t[SG_R][7] = 1'b1;
    end
    return t;
  endfunction

  // Bit d set when an operation of kind 'second' may not start d cycles
  // after one of kind 'first'.
  function automatic row_t collide_vec(input int first, input int second);
    table_t tf;
    table_t ts;
    row_t   v;
    tf = resv_table(first);
    ts = resv_table(second);
    v  = '0;
    for (int d = 0; d < WIN; d++)
      for (int s = 0; s < NUM_STAGES; s++)
        for (int k = 0; k + d < WIN; k++)
          if (tf[s][k+d] && ts[s][k]) v[d] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/ipc_request_track.sv
module ipc_request_track #(
  parameter int NUM_OPS = ipc_pkg::NUM_OPS
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_OPS-1:0]              req_i,
  input  logic [NUM_OPS-1:0]              take_i,
  output logic [NUM_OPS-1:0]              pend_o,
  output logic [NUM_OPS-1:0][NUM_OPS-1:0] older_o
);

  logic [NUM_OPS-1:0] pend_q;
  logic [NUM_OPS-1:0] kept;
  logic [NUM_OPS-1:0] fresh;

  assign kept  = pend_q & ~take_i;
  assign fresh = req_i & ~kept;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= kept | req_i;
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_row
    for (genvar j = 0; j < NUM_OPS; j++) begin : g_col
      if (i == j) begin : g_diag
        assign older_o[i][j] = 1'b0;
      end else begin : g_pair
        logic age_q;
        always_ff @(posedge clk) begin
          if (rst)                      age_q <= 1'b0;
          else if (kept[i] && kept[j])  age_q <= age_q;
          else if (kept[i] && fresh[j]) age_q <= 1'b1;
          else if (fresh[i] && kept[j]) age_q <= 1'b0;
          else if (fresh[i] && fresh[j]) age_q <= (i < j);
          else                          age_q <= 1'b0;
        end
        assign older_o[i][j] = age_q;
      end
    end

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && !take_i[i]) |=> pend_q[i]); // R9
  end

endmodule

// File: rtl/ipc_collision_state.sv
module ipc_collision_state #(
  parameter int WIN     = ipc_pkg::WIN,
  parameter int NUM_OPS = ipc_pkg::NUM_OPS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OPS-1:0] take_i,
  output logic [NUM_OPS-1:0] allow_o
);

  typedef logic [WIN-1:0] vec_t;

  for (genvar j = 0; j < NUM_OPS; j++) begin : g_dst
    vec_t forbid_q;
    vec_t contrib;

    always_comb begin
      contrib = '0;
      for (int i = 0; i < NUM_OPS; i++)
        if (take_i[i]) contrib = contrib | (vec_t'(ipc_pkg::collide_vec(i, j)) >> 1);
    end

    always_ff @(posedge clk) begin
      if (rst) forbid_q <= '0;
      else     forbid_q <= (forbid_q >> 1) | contrib;
    end

    // bit 0 covers a start in the next cycle
    assign allow_o[j] = ~forbid_q[0];
  end

endmodule

// File: rtl/ipc_stage_occupancy.sv
module ipc_stage_occupancy #(
  parameter int NUM_STAGES = ipc_pkg::NUM_STAGES,
  parameter int WIN        = ipc_pkg::WIN,
  parameter int NUM_OPS    = ipc_pkg::NUM_OPS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_OPS-1:0]    take_i,
  output logic [NUM_STAGES-1:0] busy_o
);

  typedef logic [WIN-1:0] vec_t;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    vec_t win_q;
    vec_t claim;

    always_comb begin
      ipc_pkg::table_t t;
      claim = '0;
      for (int i = 0; i < NUM_OPS; i++) begin
        t = ipc_pkg::resv_table(i);
        if (take_i[i]) claim = claim | vec_t'(t[s]);
      end
    end

    always_ff @(posedge clk) begin
      if (rst) win_q <= '0;
      else     win_q <= (win_q >> 1) | claim;
    end

    assign busy_o[s] = win_q[0];

    AST_NO_STAGE_CLASH: assert property (@(posedge clk) disable iff (rst)
      ((win_q >> 1) & claim) == '0); // R13
  end

endmodule

// File: rtl/ipc_initiation_ctrl.sv
module ipc_initiation_ctrl #(
  parameter int NUM_STAGES = ipc_pkg::NUM_STAGES,
  parameter int WIN        = ipc_pkg::WIN
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  add_req_i,
  input  logic                  mul_req_i,
  output logic                  add_grant_o,
  output logic                  mul_grant_o,
  output logic [NUM_STAGES-1:0] stage_busy_o
);

  localparam int NOPS = ipc_pkg::NUM_OPS;

  logic [NOPS-1:0]           req;
  logic [NOPS-1:0]           pend;
  logic [NOPS-1:0]           allow;
  logic [NOPS-1:0]           ok;
  logic [NOPS-1:0]           take;
  logic [NOPS-1:0]           grant_q;
  logic [NOPS-1:0][NOPS-1:0] older;

  assign req[ipc_pkg::OP_ADD] = add_req_i;
  assign req[ipc_pkg::OP_MUL] = mul_req_i;

  ipc_request_track #(.NUM_OPS(NOPS)) u_track (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req),
    .take_i  (take),
    .pend_o  (pend),
    .older_o (older)
  );

  ipc_collision_state #(.WIN(WIN), .NUM_OPS(NOPS)) u_state (
    .clk     (clk),
    .rst     (rst),
    .take_i  (take),
    .allow_o (allow)
  );

  ipc_stage_occupancy #(.NUM_STAGES(NUM_STAGES), .WIN(WIN), .NUM_OPS(NOPS)) u_occ (
    .clk    (clk),
    .rst    (rst),
    .take_i (take),
    .busy_o (stage_busy_o)
  );

  // a pending, allowed request wins unless another allowed one is older
  assign ok = pend & allow;

  always_comb begin
    take = ok;
    for (int i = 0; i < NOPS; i++)
      for (int j = 0; j < NOPS; j++)
        if (i != j && ok[i] && ok[j] && !older[i][j]) take[i] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) grant_q <= '0;
    else     grant_q <= take;
  end

  assign add_grant_o = grant_q[ipc_pkg::OP_ADD];
  assign mul_grant_o = grant_q[ipc_pkg::OP_MUL];

  AST_BUSY_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
    (add_grant_o || mul_grant_o) |-> stage_busy_o[ipc_pkg::SG_U]); // R2

  AST_GRANT_WAS_PENDING: assert property (@(posedge clk) disable iff (rst)
    add_grant_o |-> $past(pend[ipc_pkg::OP_ADD])); // R9

  AST_ADD_SPACING: assert property (@(posedge clk) disable iff (rst)
    add_grant_o |-> (!$past(add_grant_o, 1) && !$past(add_grant_o, 2))); // R5

  AST_MUL_SPACING: assert property (@(posedge clk) disable iff (rst)
    mul_grant_o |-> (!$past(mul_grant_o, 1) && !$past(mul_grant_o, 2)
                     && !$past(mul_grant_o, 3))); // R6

  AST_ADD_AFTER_MUL: assert property (@(posedge clk) disable iff (rst)
    add_grant_o |-> (!$past(mul_grant_o, 4) && !$past(mul_grant_o, 5))); // R7

endmodule

// File: tb/ipc_initiation_ctrl_bench.sv
module ipc_initiation_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       add_req_i = 1'b0;
  logic       mul_req_i = 1'b0;
  logic       add_grant_o;
  logic       mul_grant_o;
  logic [7:0] stage_busy_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_kind_q[$];
  int exp_cyc_q[$];
  string exp_tag_q[$];

  ipc_initiation_ctrl u_ipc_initiation_ctrl (
    .clk          (clk),
    .rst          (rst),
    .add_req_i    (add_req_i),
    .mul_req_i    (mul_req_i),
    .add_grant_o  (add_grant_o),
    .mul_grant_o  (mul_grant_o),
    .stage_busy_o (stage_busy_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // stage bits: U0 S1 A2 R3 M4 N5 D6 E7 ; kind 0 = add, 1 = mul
  task automatic at_cycle(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pulse(input bit a, input bit m, input int c);
    at_cycle(c);
    add_req_i = a;
    mul_req_i = m;
    @(negedge clk);
    add_req_i = 1'b0;
    mul_req_i = 1'b0;
  endtask

  task automatic expect_grant(input int kind, input int c, input string tag);
    exp_kind_q.push_back(kind);
    exp_cyc_q.push_back(c);
    exp_tag_q.push_back(tag);
  endtask

  task automatic check_busy(input int c, input logic [7:0] exp, input string tag);
    at_cycle(c);
    checks++;
    if (stage_busy_o !== exp) begin
      errors++;
      $display("FAIL %s busy at cycle %0d actual %02h expected %02h", tag, c, stage_busy_o, exp);
    end
  endtask

  task automatic check_drained(input string tag);
    checks++;
    if (exp_kind_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing grants actual pending=%0d expected 0", tag, exp_kind_q.size());
      exp_kind_q.delete(); exp_cyc_q.delete(); exp_tag_q.delete();
    end
  endtask

  task automatic settle(output int base);
    at_cycle(cyc + 12);
    base = cyc;
  endtask

  // monitor: pops the scoreboard on each grant
  always @(negedge clk) begin
    int k;
    int c;
    string t;
    if (!rst && (add_grant_o || mul_grant_o)) begin
      checks++;
      if (add_grant_o && mul_grant_o) begin
        errors++;
        $display("FAIL R2 two grants at cycle %0d actual add=1 mul=1 expected one", cyc);
      end else if (exp_kind_q.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected grant kind %0d at cycle %0d expected none", mul_grant_o, cyc);
      end else begin
        k = exp_kind_q.pop_front();
        c = exp_cyc_q.pop_front();
        t = exp_tag_q.pop_front();
        if (k != int'(mul_grant_o) || c != cyc) begin
          errors++;
          $display("FAIL %s grant actual kind %0d cycle %0d expected kind %0d cycle %0d",
                   t, mul_grant_o, cyc, k, c);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int b;
    repeat (8) @(negedge clk);
    checks++;
    if (add_grant_o !== 1'b0 || mul_grant_o !== 1'b0 || stage_busy_o !== 8'h00) begin
      errors++;
      $display("FAIL R1 in reset actual %b%b %02h expected 00 00", add_grant_o, mul_grant_o, stage_busy_o);
    end
    rst = 1'b0;
    @(negedge clk);
    check_busy(cyc, 8'h00, "R1");

    // single add: latency and table
    settle(b);
    expect_grant(0, b+2, "R2");
    pulse(1, 0, b);
    check_busy(b+2, 8'h01, "R3");
    check_busy(b+3, 8'h06, "R3");
    check_busy(b+4, 8'h0C, "R3");
    check_busy(b+5, 8'h0A, "R3");
    check_busy(b+6, 8'h00, "R3");

    // single multiply: table
    settle(b);
    expect_grant(1, b+2, "R4");
    pulse(0, 1, b);
    check_busy(b+2, 8'h01, "R4");
    check_busy(b+3, 8'h90, "R4");
    check_busy(b+4, 8'h10, "R4");
    check_busy(b+5, 8'h10, "R4");
    check_busy(b+6, 8'h10, "R4");
    check_busy(b+7, 8'h20, "R4");
    check_busy(b+8, 8'h24, "R4");
    check_busy(b+9, 8'h08, "R4");
    check_busy(b+10, 8'h00, "R4");

    // add after add: spacing 3
    settle(b);
    expect_grant(0, b+2, "R5");
    expect_grant(0, b+5, "R5");
    pulse(1, 0, b);
    pulse(1, 0, b+1);
    settle(b);
    check_drained("R5");

    // multiply after multiply: spacing 4
    settle(b);
    expect_grant(1, b+2, "R6");
    expect_grant(1, b+6, "R6");
    pulse(0, 1, b);
    pulse(0, 1, b+1);
    settle(b);
    check_drained("R6");

    // add 3 after multiply: allowed, overlapping occupancy, add finishes first
    settle(b);
    expect_grant(1, b+2, "R7");
    expect_grant(0, b+5, "R7");
    pulse(0, 1, b);
    pulse(1, 0, b+3);
    check_busy(b+6, 8'h16, "R13");
    check_busy(b+8, 8'h2E, "R13");
    check_busy(b+9, 8'h08, "R13");
    check_busy(b+10, 8'h00, "R13");

    // add asked 4 after multiply: pushed to 6
    settle(b);
    expect_grant(1, b+2, "R7");
    expect_grant(0, b+8, "R7");
    pulse(0, 1, b);
    pulse(1, 0, b+4);
    settle(b);
    check_drained("R7");

    // multiply right after add
    settle(b);
    expect_grant(0, b+2, "R8");
    expect_grant(1, b+3, "R8");
    pulse(1, 0, b);
    pulse(0, 1, b+1);

    // same-cycle strobes: add first
    settle(b);
    expect_grant(0, b+2, "R10");
    expect_grant(1, b+3, "R10");
    pulse(1, 1, b);

    // older pending add beats a fresh multiply
    settle(b);
    expect_grant(0, b+2, "R11");
    expect_grant(0, b+5, "R11");
    expect_grant(1, b+6, "R11");
    pulse(1, 0, b);
    pulse(1, 0, b+1);
    pulse(0, 1, b+3);

    // blocked older multiply, younger add bypasses
    settle(b);
    expect_grant(1, b+2, "R9");
    expect_grant(0, b+5, "R9");
    expect_grant(1, b+6, "R9");
    pulse(0, 1, b);
    pulse(0, 1, b+2);
    pulse(1, 0, b+3);

    // extra strobe while pending is absorbed
    settle(b);
    expect_grant(0, b+2, "R12");
    expect_grant(0, b+5, "R12");
    pulse(1, 0, b);
    pulse(1, 0, b+1);
    pulse(1, 0, b+2);
    settle(b);
    check_drained("R12");
    check_busy(cyc, 8'h00, "R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule